// File: doc/BRIEF.md
# Auto-Advancing Indexed State Memory Reader

This block gives a host read access to several small per-ring state memories through one register address per memory. The entry that a read returns is not taken from the bus address. It comes from a separately programmed control register that holds a read index and a stride. After every read of a memory-backed register, the stride is added to the index. Software sets the index to 0 and the stride to 1, and then dumps a whole memory with back-to-back reads.

The memories are filled by an on-chip hardware writer, for example a timer engine, through a simple write port. The host side has three parts: a write strobe and a read strobe for the control register, and a one-hot set of read strobes, one for each memory-backed register. Every read returns its data one cycle later, with a valid flag.

Top module: `ring_state_reader`

## Requirements
- R1: After reset the index and the stride are both 0 and `rd_valid` is low. A control register read issued right after reset returns 0.
- R2: A control register write stores `cfg_wdata[7:0]` as the index and `cfg_wdata[15:8]` as the stride. A control register read returns that stride and index in the same bit positions, with bits 63:16 reading as zero whatever was written there.
- R3: A strobe on `mem_rd[m]` returns entry `index` of memory `m` on `rd_data`, with `rd_valid` high, in the cycle after the strobe.
- R4: After each memory read the index becomes (index + stride) modulo 256. For example, index 254 with stride 3 becomes 1.
- R5: A memory read taken while the index is 16 or more returns all-zero data, and the index still advances.
- R6: Reading the control register leaves the index and the stride unchanged.
- R7: When a control register write and a memory read occur in the same cycle, the read returns the entry at the old index. The index and stride then take the written values, with no advance added.
- R8: A hardware write (`hw_we` with `hw_sel`, `hw_addr`, `hw_wdata`) updates that entry, and later memory reads of it return the new value.
- R9: With a stride of 0, repeated memory reads return the same entry.
- R10: `rd_valid` is high exactly in the cycle after a read strobe of any kind. It stays low after idle cycles and after control register writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the index/stride control register |
| cfg_rd | input | 1 | Read strobe for the control register |
| cfg_wdata | input | 64 | Control register write data (index 7:0, stride 15:8) |
| mem_rd | input | 3 | One-hot read strobes, one per memory-backed register |
| hw_we | input | 1 | Hardware writer strobe |
| hw_sel | input | 2 | Memory chosen by the hardware writer |
| hw_addr | input | 4 | Entry chosen by the hardware writer |
| hw_wdata | input | 64 | Hardware writer data |
| rd_valid | output | 1 | Read response valid, one cycle after a strobe |
| rd_data | output | 64 | Read response data |

## Verification
The embedded assertions check the following on every cycle. The index advances by the stride after a memory read. A control write overrides that advance. Idle cycles and control reads leave the index and stride untouched. `rd_valid` pairs one-for-one with strobes. Reserved bits and out-of-range reads return zeros. Only the bench scenarios can show that the right entry of the right memory comes back. The same holds for modulo-256 wrapping over a full dump sequence, for the old-index data on a simultaneous write and read, and for hardware updates becoming visible to later reads.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned STEP_W = 8;
  localparam int unsigned CTRL_W = IDX_W + STEP_W;

  // Control register layout: stride above index.
  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [IDX_W-1:0]  idx;
  } ctrl_t;
endpackage

// File: rtl/rsr_index_ctrl.sv
module rsr_index_ctrl
  import rsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  input  logic  adv,
  output ctrl_t ctrl_q
);
  ctrl_t ctrl_d;
  logic  ctrl_en;

  // Next state: a write overrides any advance in the same cycle.
  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = wr_en | adv;
    if (wr_en) begin
      ctrl_d = wr_val;
    end else if (adv) begin
      ctrl_d.idx = ctrl_q.idx + ctrl_q.step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // R4: advance by the stride, wrapping at the index width
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en) |=> (ctrl_q.idx == IDX_W'($past(ctrl_q.idx) + $past(ctrl_q.step))));
  // R7: written value wins over an advance
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == $past(wr_val)));
  // R6: no write and no memory read leaves the register alone
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !adv) |=> $stable(ctrl_q));
endmodule

// File: rtl/rsr_state_bank.sv
module rsr_state_bank #(
  parameter int unsigned NUM_MEMS = 3,
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned DATA_W   = 64,
  localparam int unsigned SEL_W   = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1,
  localparam int unsigned ADDR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              hw_we,
  input  logic [SEL_W-1:0]  hw_sel,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word [NUM_MEMS];

  for (genvar g = 0; g < NUM_MEMS; g++) begin : g_mem
    logic [DATA_W-1:0] store [ENTRIES];
    logic              we_g;

    assign we_g = hw_we && (hw_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (we_g) begin
        store[hw_addr] <= hw_wdata;
      end
    end

    assign word[g] = store[rd_addr];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_MEMS; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_data = word[i];
      end
    end
  end
endmodule

// File: rtl/rsr_rd_resp.sv
module rsr_rd_resp #(
  parameter int unsigned BUS_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [BUS_W-1:0] data_d,
  output logic             valid_q,
  output logic [BUS_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (fire) begin
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/ring_state_reader.sv
module ring_state_reader
  import rsr_pkg::*;
#(
  parameter int unsigned NUM_MEMS = 3,
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned BUS_W    = 64,
  localparam int unsigned SEL_W   = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1,
  localparam int unsigned ADDR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [BUS_W-1:0]    cfg_wdata,
  input  logic [NUM_MEMS-1:0] mem_rd,
  input  logic                hw_we,
  input  logic [SEL_W-1:0]    hw_sel,
  input  logic [ADDR_W-1:0]   hw_addr,
  input  logic [DATA_W-1:0]   hw_wdata,
  output logic                rd_valid,
  output logic [BUS_W-1:0]    rd_data
);
  ctrl_t             ctrl_q;
  ctrl_t             wr_val;
  logic              mem_any;
  logic              in_range;
  logic [SEL_W-1:0]  mem_sel;
  logic [DATA_W-1:0] bank_data;
  logic [BUS_W-1:0]  resp_d;
  logic              fire;
  logic              unused_hi;

  assign wr_val    = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
  assign unused_hi = ^cfg_wdata[BUS_W-1:CTRL_W];
  assign mem_any   = |mem_rd;
  assign in_range  = (ctrl_q.idx < IDX_W'(ENTRIES));
  assign fire      = mem_any | cfg_rd;

  always_comb begin
    mem_sel = '0;
    for (int i = 0; i < NUM_MEMS; i++) begin
      if (mem_rd[i]) begin
        mem_sel = SEL_W'(i);
      end
    end
  end

  rsr_index_ctrl u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .wr_val (wr_val),
    .adv    (mem_any),
    .ctrl_q (ctrl_q)
  );

  rsr_state_bank #(
    .NUM_MEMS (NUM_MEMS),
    .ENTRIES  (ENTRIES),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk      (clk),
    .hw_we    (hw_we),
    .hw_sel   (hw_sel),
    .hw_addr  (hw_addr),
    .hw_wdata (hw_wdata),
    .rd_sel   (mem_sel),
    .rd_addr  (ctrl_q.idx[ADDR_W-1:0]),
    .rd_data  (bank_data)
  );

  // Response select: memory entry, zero when out of range, or control value.
  always_comb begin
    resp_d = '0;
    if (mem_any) begin
      if (in_range) begin
        resp_d = BUS_W'(bank_data);
      end
    end else if (cfg_rd) begin
      resp_d = BUS_W'(ctrl_q);
    end
  end

  rsr_rd_resp #(.BUS_W(BUS_W)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .data_d  (resp_d),
    .valid_q (rd_valid),
    .data_q  (rd_data)
  );

  // Usage rule: at most one read strobe per cycle
  a_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, cfg_rd}));
  // R3: every read strobe gets a response next cycle
  a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rd_valid);
  // R10: no response without a strobe
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rd_valid);
  // R5: out-of-range index yields zeros
  a_r5_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_any && (ctrl_q.idx >= IDX_W'(ENTRIES))) |=> (rd_data == '0));
  // R2: reserved control bits read back as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> (rd_data[BUS_W-1:CTRL_W] == '0));
endmodule

// File: tb/ring_state_reader_tb.sv
`timescale 1ns/1ps
module ring_state_reader_tb;
  localparam int NM = 3;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [63:0] cfg_wdata;
  logic [NM-1:0] mem_rd;
  logic        hw_we;
  logic [1:0]  hw_sel;
  logic [3:0]  hw_addr;
  logic [63:0] hw_wdata;
  logic        rd_valid;
  logic [63:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ring_state_reader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .mem_rd(mem_rd), .hw_we(hw_we), .hw_sel(hw_sel),
    .hw_addr(hw_addr), .hw_wdata(hw_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Vector: {op[1:0], mem[1:0], arg[15:0]}; op 0 = control write (arg = value),
  // 1 = memory read (arg = expected index), 2 = control read (arg = expected value)
  localparam logic [19:0] VEC [0:NV-1] = '{
    {2'd0, 2'd0, 16'h0100},
    {2'd1, 2'd0, 16'd0},
    {2'd1, 2'd0, 16'd1},
    {2'd1, 2'd1, 16'd2},
    {2'd2, 2'd0, 16'h0103},
    {2'd1, 2'd2, 16'd3},
    {2'd0, 2'd0, 16'h030E},
    {2'd1, 2'd0, 16'd14},
    {2'd1, 2'd1, 16'd17},
    {2'd2, 2'd0, 16'h0314},
    {2'd0, 2'd0, 16'h03FE},
    {2'd1, 2'd0, 16'd254},
    {2'd1, 2'd0, 16'd1}
  };

  function automatic logic [63:0] pat(int m, int e);
    return {8'hA5, 8'(m), 8'(e), 8'h3C, 32'(e) * 32'h01010101 ^ 32'(m) * 32'h11111111};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic hw_write(int m, int e, logic [63:0] d);
    hw_we = 1'b1; hw_sel = 2'(m); hw_addr = 4'(e); hw_wdata = d;
    @(negedge clk);
    hw_we = 1'b0;
  endtask

  task automatic cfg_write(logic [15:0] v);
    cfg_wr = 1'b1; cfg_wdata = {48'hDEAD_BEEF_F00D, v};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(output logic [63:0] d, output logic v);
    cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic mem_read(int m, output logic [63:0] d, output logic v);
    mem_rd = '0; mem_rd[m] = 1'b1;
    @(negedge clk);
    mem_rd = '0;
    d = rd_data; v = rd_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic        v;
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; cfg_wdata = '0; mem_rd = '0;
    hw_we = 0; hw_sel = '0; hw_addr = '0; hw_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 valid", 64'(rd_valid), 64'd0);
    cfg_read(d, v);
    chk("R1 ctrl", d, 64'd0);

    for (int m = 0; m < NM; m++)
      for (int e = 0; e < 16; e++)
        hw_write(m, e, pat(m, e));

    // Table walk
    for (int i = 0; i < NV; i++) begin
      int op  = int'(VEC[i][19:18]);
      int mm  = int'(VEC[i][17:16]);
      int arg = int'(VEC[i][15:0]);
      if (op == 0) begin
        cfg_write(16'(arg));
        chk("R10 no valid after write", 64'(rd_valid), 64'd0);
      end else if (op == 1) begin
        mem_read(mm, d, v);
        chk("R3 valid", 64'(v), 64'd1);
        if (arg >= 16) chk("R5 out of range", d, 64'd0);
        else chk("R4 entry", d, pat(mm, arg));
      end else begin
        cfg_read(d, v);
        chk("R6 ctrl read", d, 64'(arg));
        chk("R2 ctrl valid", 64'(v), 64'd1);
      end
    end

    // R10: idle cycle
    @(negedge clk);
    chk("R10 idle", 64'(rd_valid), 64'd0);

    // R7: same-cycle write and read
    cfg_write(16'h0102);
    cfg_wr = 1'b1; cfg_wdata = 64'h0000_0000_0000_0109; mem_rd = 3'b010;
    @(negedge clk);
    cfg_wr = 1'b0; mem_rd = '0;
    chk("R7 old index data", rd_data, pat(1, 2));
    mem_read(1, d, v);
    chk("R7 written index", d, pat(1, 9));
    cfg_read(d, v);
    chk("R7 ctrl after", d, 64'h010A);

    // R8: hardware update visible
    hw_write(1, 9, 64'h0123_4567_89AB_CDEF);
    cfg_write(16'h0109);
    mem_read(1, d, v);
    chk("R8 updated entry", d, 64'h0123_4567_89AB_CDEF);

    // R9: zero stride repeats
    cfg_write(16'h0007);
    mem_read(0, d, v);
    chk("R9 first", d, pat(0, 7));
    mem_read(0, d, v);
    chk("R9 repeat", d, pat(0, 7));
    mem_read(2, d, v);
    chk("R9 other memory", d, pat(2, 7));

    // R1: reset in mid-run clears the control register
    cfg_write(16'h0205);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 64'(rd_valid), 64'd0);
    cfg_read(d, v);
    chk("R1 ctrl after reset", d, 64'd0);

    finish_run();
  end
endmodule